// File: doc/BRIEF.md
# Shadowed PWM Comparison Update Unit

This block keeps the compare settings of one PWM comparison unit that watches a reference PWM channel. Software may rewrite those settings while the channel is running. Every write lands in a shadow register first. The active compare value and the active configuration change only at a safe boundary. That boundary is a period end of the reference channel that also ends the programmable comparison update period. Because of this, a comparison can never see a value that is only partly updated.

A new compare value is only armed when a configuration write follows it. The configuration word holds a comparison enable bit and the update-period setting. The update-period setting is itself double-buffered. The block outputs the active value, the active configuration and the update-period count. It also gives a one-clock match pulse when an external PWM counter reaches the active value.

Top module: `pcsu_top`

## Requirements
- R1: When the synchronous active-low reset is asserted, the active value, the active configuration, the update-period count and the match output all become zero, and no update is pending.
- R2: On each period-end pulse, the update-period count goes up by one. When the count already equals the active update-period setting (configuration bits [UPR_W:1]), it returns to zero instead.
- R3: The update-period count never exceeds the active update-period setting.
- R4: The active value and configuration change only in the cycle after a period-end pulse that finds the count equal to the setting while an update is pending. An update becomes pending through a configuration write. It stops being pending when that transfer takes place. At no other time do they change.
- R5: A value write that has no later configuration write is not applied at a boundary. It is kept, and a later configuration write arms it.
- R6: When the shadows are written several times between two transfers, the transfer applies the last configuration written and the last value written before that configuration write.
- R7: A value write and a configuration write in the same cycle are paired, so the transfer applies that value.
- R8: The update-period setting is applied at the same boundary as the rest of the configuration, and from that point it governs when the count wraps.
- R9: Configuration bit 0 is the enable. With bit 0 set, the match output is high for exactly one clock. That clock is the cycle after the PWM counter input first equals the active value. While the equality lasts, no further pulse follows.
- R10: While the active enable bit is clear, the match output stays low, whatever the PWM counter value.
- R11: A configuration write in the same cycle as a transfer does not affect that transfer. It stays pending for the next boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_val | input | 1 | Write strobe for the value shadow |
| val_wdata | input | VAL_W | Value to write |
| wr_cfg | input | 1 | Write strobe for the configuration shadow |
| cfg_wdata | input | UPR_W+1 | Configuration to write: bit 0 enable, bits [UPR_W:1] update period |
| period_end | input | 1 | One-clock pulse at the end of each reference PWM period |
| pwm_cnt | input | VAL_W | Counter of the reference PWM channel |
| act_val | output | VAL_W | Active compare value |
| act_cfg | output | UPR_W+1 | Active configuration |
| upd_cnt | output | UPR_W | Update-period count |
| match | output | 1 | One-clock compare-match pulse |

## Verification
The bench targets four cases:
- A value write with no configuration write after it. A design that dropped the pairing rule would apply the value early; one that lost the write would never apply it.
- A configuration write in the same cycle as a value write, and one in the same cycle as a boundary. A design that got the ordering wrong would apply a stale value, or lose the late write altogether.
- A change of the update-period setting. A design that applied the new setting at once, rather than at the boundary, would shift the wrap point.
- A PWM counter that rests on the compare value. A level-style match would hold high for several cycles instead of pulsing once.

// File: rtl/pcsu_pkg.sv
// Package: shared field positions of the comparison configuration word.
// Assumes the enable bit sits at bit 0 and the update period just above it.
package pcsu_pkg;
    localparam int PCSU_EN_BIT  = 0;
    localparam int PCSU_UPR_LSB = 1;
endpackage

// File: rtl/pcsu_shadow.sv
// Shadow stage: holds the value written last, the value armed by the most
// recent configuration write, the configuration shadow and the pending flag.
// Assumes xfer is asserted only while pend is high.
module pcsu_shadow #(
    parameter int VAL_W = 16,
    parameter int CFG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_val,
    input  logic [VAL_W-1:0] val_wdata,
    input  logic             wr_cfg,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             xfer,
    output logic [VAL_W-1:0] pair_val,
    output logic [CFG_W-1:0] cfg_sh,
    output logic             pend
);
    logic [VAL_W-1:0] val_sh;

    // Latest value write, kept until it is overwritten.
    always_ff @(posedge clk) begin
        if (!rst_n)      val_sh <= '0;
        else if (wr_val) val_sh <= val_wdata;
    end

    // A configuration write arms the value written before or with it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pair_val <= '0;
            cfg_sh   <= '0;
        end else if (wr_cfg) begin
            pair_val <= wr_val ? val_wdata : val_sh;
            cfg_sh   <= cfg_wdata;
        end
    end

    // Pending flag: set by a configuration write, cleared by a transfer.
    always_ff @(posedge clk) begin
        if (!rst_n)      pend <= 1'b0;
        else if (wr_cfg) pend <= 1'b1;
        else if (xfer)   pend <= 1'b0;
    end

    assert_pair_same_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cfg && wr_val) |=> (pair_val == $past(val_wdata)));
    assert_pend_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && !wr_cfg) |=> !pend);
    assert_late_cfg_pends_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && wr_cfg) |=> pend);
endmodule

// File: rtl/pcsu_upd_timer.sv
// Update-period timer: counts reference period ends and flags expiry.
// Assumes upr changes only in the cycle after an expiry.
module pcsu_upd_timer #(
    parameter int UPR_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             period_end,
    input  logic [UPR_W-1:0] upr,
    output logic [UPR_W-1:0] cnt,
    output logic             expire
);
    // Expiry: a period end that finds the count at the programmed setting.
    always_comb expire = period_end && (cnt == upr);

    // Count period ends and wrap to zero on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (expire)     cnt <= '0;
        else if (period_end) cnt <= cnt + UPR_W'(1);
    end

    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= upr);
    assert_cnt_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (period_end && cnt != upr) |=> (cnt == $past(cnt) + UPR_W'(1)));
    assert_cnt_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !period_end |=> $stable(cnt));
endmodule

// File: rtl/pcsu_match.sv
// Match generator: one-clock pulse when the PWM counter reaches the active value.
// Assumes en and val are the registered active settings.
module pcsu_match #(
    parameter int VAL_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [VAL_W-1:0] val,
    input  logic [VAL_W-1:0] pwm_cnt,
    output logic             match
);
    logic hit;
    logic hit_q;

    // Enabled equality between counter and active value.
    always_comb hit = en && (pwm_cnt == val);

    // Register the first cycle of equality as the pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_q <= 1'b0;
            match <= 1'b0;
        end else begin
            hit_q <= hit;
            match <= hit && !hit_q;
        end
    end

    assert_match_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> !match);
    assert_match_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !match);
endmodule

// File: rtl/pcsu_top.sv
// Top: active compare value and configuration, loaded from the shadows at
// a period end that expires the update period while an update is pending.
// Assumes period_end is a one-clock pulse from the reference channel.
module pcsu_top
    import pcsu_pkg::*;
#(
    parameter int VAL_W = 16,
    parameter int UPR_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_val,
    input  logic [VAL_W-1:0]     val_wdata,
    input  logic                 wr_cfg,
    input  logic [UPR_W:0]       cfg_wdata,
    input  logic                 period_end,
    input  logic [VAL_W-1:0]     pwm_cnt,
    output logic [VAL_W-1:0]     act_val,
    output logic [UPR_W:0]       act_cfg,
    output logic [UPR_W-1:0]     upd_cnt,
    output logic                 match
);
    localparam int CFG_W = UPR_W + 1;

    logic [VAL_W-1:0] pair_val;
    logic [CFG_W-1:0] cfg_sh;
    logic             pend;
    logic             expire;
    logic             xfer;

    // Transfer only when the boundary comes with an armed update.
    always_comb xfer = expire && pend;

    pcsu_shadow #(.VAL_W(VAL_W), .CFG_W(CFG_W)) i_shadow (
        .clk(clk), .rst_n(rst_n), .wr_val(wr_val), .val_wdata(val_wdata),
        .wr_cfg(wr_cfg), .cfg_wdata(cfg_wdata), .xfer(xfer),
        .pair_val(pair_val), .cfg_sh(cfg_sh), .pend(pend)
    );

    pcsu_upd_timer #(.UPR_W(UPR_W)) i_timer (
        .clk(clk), .rst_n(rst_n), .period_end(period_end),
        .upr(act_cfg[PCSU_UPR_LSB +: UPR_W]), .cnt(upd_cnt), .expire(expire)
    );

    // Active registers, loaded from the shadows at a transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_val <= '0;
            act_cfg <= '0;
        end else if (xfer) begin
            act_val <= pair_val;
            act_cfg <= cfg_sh;
        end
    end

    pcsu_match #(.VAL_W(VAL_W)) i_match (
        .clk(clk), .rst_n(rst_n), .en(act_cfg[PCSU_EN_BIT]), .val(act_val),
        .pwm_cnt(pwm_cnt), .match(match)
    );

    assert_act_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer |=> ($stable(act_val) && $stable(act_cfg)));
    assert_xfer_at_boundary_R4: assert property (@(posedge clk) disable iff (!rst_n)
        xfer |-> (period_end && pend));
    assert_new_period_R8: assert property (@(posedge clk) disable iff (!rst_n)
        xfer |=> (upd_cnt == '0));
endmodule

// File: tb/test_pcsu_top.sv
module test_pcsu_top;
    localparam int VAL_W = 16;
    localparam int UPR_W = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_val = 1'b0;
    logic [VAL_W-1:0] val_wdata = '0;
    logic             wr_cfg = 1'b0;
    logic [UPR_W:0]   cfg_wdata = '0;
    logic             period_end = 1'b0;
    logic [VAL_W-1:0] pwm_cnt = '0;
    logic [VAL_W-1:0] act_val;
    logic [UPR_W:0]   act_cfg;
    logic [UPR_W-1:0] upd_cnt;
    logic             match;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done = 0;

    // Reference model state, kept as plain integers.
    int m_last_val, m_armed_val, m_cfg_sh, m_pend;
    int m_act_val, m_act_cfg, m_cnt, m_hit_prev, m_match;

    pcsu_top #(.VAL_W(VAL_W), .UPR_W(UPR_W)) i_pcsu_top (
        .clk(clk), .rst_n(rst_n), .wr_val(wr_val), .val_wdata(val_wdata),
        .wr_cfg(wr_cfg), .cfg_wdata(cfg_wdata), .period_end(period_end),
        .pwm_cnt(pwm_cnt), .act_val(act_val), .act_cfg(act_cfg),
        .upd_cnt(upd_cnt), .match(match)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    // Behavioural reference, advanced on every rising edge.
    always @(posedge clk) begin
        int period, hit, boundary;
        if (!rst_n) begin
            m_last_val = 0; m_armed_val = 0; m_cfg_sh = 0; m_pend = 0;
            m_act_val = 0; m_act_cfg = 0; m_cnt = 0; m_hit_prev = 0; m_match = 0;
        end else begin
            period = m_act_cfg / 2;
            hit = ((m_act_cfg % 2) == 1 && int'(pwm_cnt) == m_act_val) ? 1 : 0;
            m_match = (hit == 1 && m_hit_prev == 0) ? 1 : 0;
            m_hit_prev = hit;
            boundary = (period_end && m_cnt == period) ? 1 : 0;
            if (boundary == 1 && m_pend == 1) begin
                m_act_val = m_armed_val;
                m_act_cfg = m_cfg_sh;
                m_pend = 0;
            end
            if (period_end) m_cnt = (boundary == 1) ? 0 : m_cnt + 1;
            if (wr_cfg) begin
                m_armed_val = wr_val ? int'(val_wdata) : m_last_val;
                m_cfg_sh = int'(cfg_wdata);
                m_pend = 1;
            end
            if (wr_val) m_last_val = int'(val_wdata);
        end
    end

    // Compare with the model away from the active edge, every cycle.
    always @(negedge clk) begin
        cycles++;
        if (rst_n && !done) begin
            chk("R4 act_val", int'(act_val), m_act_val);
            chk("R8 act_cfg", int'(act_cfg), m_act_cfg);
            chk("R2 upd_cnt", int'(upd_cnt), m_cnt);
            chk("R9 match", int'(match), m_match);
            chk("R3 cnt bound", (int'(upd_cnt) <= int'(act_cfg) / 2) ? 1 : 0, 1);
        end
        if (cycles > 100000 && !done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 100000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic cyc(input bit wv, input int vd, input bit wc, input int cd, input bit pe);
        wr_val = wv; val_wdata = VAL_W'(vd);
        wr_cfg = wc; cfg_wdata = (UPR_W + 1)'(cd);
        period_end = pe;
        @(negedge clk);
        wr_val = 0; wr_cfg = 0; period_end = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 act_val", int'(act_val), 0);
        chk("R1 act_cfg", int'(act_cfg), 0);
        chk("R1 upd_cnt", int'(upd_cnt), 0);
        chk("R1 match", int'(match), 0);
        rst_n = 1;
        @(negedge clk);

        // R5: lone value write is not applied at a boundary
        cyc(1, 100, 0, 0, 0);
        cyc(0, 0, 0, 0, 1);
        chk("R5 lone value held back", int'(act_val), 0);
        // R4: configuration write waits for the boundary
        cyc(0, 0, 1, 3, 0);
        chk("R4 no change before boundary", int'(act_val), 0);
        cyc(0, 0, 0, 0, 1);
        chk("R4 transfer value", int'(act_val), 100);
        chk("R4 transfer cfg", int'(act_cfg), 3);
        // R8 and R2: new period of one governs the count
        cyc(0, 0, 0, 0, 1);
        chk("R8 count under new period", int'(upd_cnt), 1);
        // R6: several writes, last ones win
        cyc(1, 150, 0, 0, 0);
        cyc(1, 200, 0, 0, 0);
        cyc(0, 0, 1, 3, 0);
        cyc(0, 0, 0, 0, 1);
        chk("R6 last value", int'(act_val), 200);
        chk("R2 wrap", int'(upd_cnt), 0);
        // R7: same-cycle pairing; boundary needs count at period
        cyc(1, 50, 1, 1, 0);
        cyc(0, 0, 0, 0, 1);
        chk("R4 not yet expired", int'(act_val), 200);
        cyc(0, 0, 0, 0, 1);
        chk("R7 paired value", int'(act_val), 50);
        chk("R7 paired cfg", int'(act_cfg), 1);
        // R11: configuration write in the transfer cycle
        cyc(1, 60, 1, 1, 0);
        cyc(1, 77, 1, 1, 1);
        chk("R11 earlier pair applied", int'(act_val), 60);
        cyc(0, 0, 0, 0, 1);
        chk("R11 late pair applied next", int'(act_val), 77);
        // R5: kept value is armed by a later configuration write
        cyc(1, 90, 0, 0, 0);
        cyc(0, 0, 0, 0, 1);
        chk("R5 still old", int'(act_val), 77);
        cyc(0, 0, 1, 1, 0);
        cyc(0, 0, 0, 0, 1);
        chk("R5 kept value applied", int'(act_val), 90);
        // R9: single pulse while counter rests on the value
        pwm_cnt = 89; cyc(0, 0, 0, 0, 0);
        pwm_cnt = 90; cyc(0, 0, 0, 0, 0);
        chk("R9 pulse", int'(match), 1);
        cyc(0, 0, 0, 0, 0);
        chk("R9 no repeat", int'(match), 0);
        cyc(0, 0, 0, 0, 0);
        chk("R9 no repeat later", int'(match), 0);
        // R10: enable cleared blocks matches
        pwm_cnt = 0;
        cyc(0, 0, 1, 0, 0);
        cyc(0, 0, 0, 0, 1);
        chk("R10 cfg disabled", int'(act_cfg), 0);
        pwm_cnt = 90; cyc(0, 0, 0, 0, 0);
        chk("R10 no match", int'(match), 0);
        cyc(0, 0, 0, 0, 0);
        chk("R10 no match later", int'(match), 0);

        // Random traffic against the model
        for (int i = 0; i < 4000; i++) begin
            pwm_cnt = VAL_W'($urandom_range(0, 7));
            cyc(($urandom_range(0, 3) == 0), int'($urandom_range(0, 7)),
                ($urandom_range(0, 5) == 0), int'($urandom_range(0, 31)),
                ($urandom_range(0, 1) == 1));
        end
        // R1: reset mid-run clears everything
        rst_n = 0;
        @(negedge clk);
        chk("R1 reset act_val", int'(act_val), 0);
        chk("R1 reset upd_cnt", int'(upd_cnt), 0);
        chk("R1 reset act_cfg", int'(act_cfg), 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule